// File: doc/BRIEF.md
# Loop Load Address Pattern Predictor

This block watches the addresses of loads that repeat once per loop iteration and learns, for each tracked load slot, how the address moves from one iteration to the next. When a pattern has been confirmed it gives the address of the next iteration, so that a buffer of pre-executed loads can fetch that data early. Three patterns are recognised: a fixed stride, a constant address (stride of zero) and pointer chasing, where the data a load returns is the address of its next execution.

Each slot is a small state machine with the states EMPTY (nothing seen), SEEN (one address held), TRAIN (a candidate stride held, not yet trusted), STRIDE (stride confirmed, including the constant case) and POINTER (pointer chasing confirmed). A slot moves EMPTY to SEEN on its first load and SEEN to TRAIN on its second, when it takes the address difference as the candidate stride. From TRAIN, a load at the expected address moves the slot to STRIDE. A load at the data returned by the previous execution moves it to POINTER. Any other load keeps it in TRAIN with a new candidate stride. In STRIDE or POINTER, a matching load keeps the state. A mismatching load raises a mispredict and drops the slot back to TRAIN. Every prediction is recorded as outstanding until the slot's next load, and a store to that address invalidates it.

Top module: `lap_predictor`

## Requirements
- R1: After reset every slot is EMPTY and all outputs are low (`pred_valid`, `mispredict`, `inval_mask`). A load on a slot after reset therefore starts training from scratch.
- R2: The first and second loads observed on a slot produce no prediction and no mispredict.
- R3: In TRAIN, a load whose address equals the previous address plus the held stride confirms the stride. In the cycle after the load, `pred_valid` is high, `pred_slot` names the slot and `pred_addr` is the load address plus the stride. `pred_kind` is 1 for a non-zero stride.
- R4: A confirmed stride of zero is the constant pattern. The prediction repeats the load address and `pred_kind` is 2.
- R5: In TRAIN, a load that misses the stride check but whose address equals the data returned by the slot's previous load enters pointer mode. The prediction is the data returned by this load and `pred_kind` is 3. Each further load at the previously returned data predicts again.
- R6: In STRIDE or POINTER, a load at any other address gives `mispredict` high and `mispredict_slot` set to the slot in the next cycle, with no prediction. The slot returns to TRAIN, where one further load at the new stride confirms again.
- R7: A store whose address equals a slot's outstanding predicted address sets that slot's bit of `inval_mask` in the next cycle and clears the outstanding entry. A repeated store to the same address then sets no bit.
- R8: A store that matches no outstanding predicted address leaves `inval_mask` at zero.
- R9: Slots train and predict independently. Loads on one slot leave the state of the others unchanged.
- R10: A mismatch while still in TRAIN raises no mispredict. The slot only takes the new candidate stride.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A tracked load has executed this cycle |
| ld_slot | input | SLOT_W | Slot of that load |
| ld_addr | input | XLEN | Address of that load |
| ld_data | input | XLEN | Data the load returned |
| st_valid | input | 1 | A store is checked this cycle |
| st_addr | input | XLEN | Store address |
| pred_valid | output | 1 | A next-iteration address is offered |
| pred_slot | output | SLOT_W | Slot of the prediction |
| pred_addr | output | XLEN | Predicted next address |
| pred_kind | output | 2 | 1 stride, 2 constant, 3 pointer |
| mispredict | output | 1 | Confirmed prediction was wrong, cancel and reissue |
| mispredict_slot | output | SLOT_W | Slot that mispredicted |
| inval_mask | output | NUM_SLOTS | Slots whose buffered load a store hit |

## Verification
The bench builds the block with its defaults: four slots and 32-bit addresses and data. With these settings, one run can hold a stride slot, a constant slot and a pointer slot side by side and check that they do not disturb each other. The 32-bit width lets the pointer chain use arbitrary returned data as addresses. The four-bit invalidate mask lets the bench see which slot a store hit.

// File: rtl/lap_pkg.sv
package lap_pkg;

    typedef enum logic [2:0] {
        SL_EMPTY   = 3'd0,
        SL_SEEN    = 3'd1,
        SL_TRAIN   = 3'd2,
        SL_STRIDE  = 3'd3,
        SL_POINTER = 3'd4
    } slot_state_e;

    typedef enum logic [1:0] {
        KIND_NONE   = 2'd0,
        KIND_STRIDE = 2'd1,
        KIND_CONST  = 2'd2,
        KIND_PTR    = 2'd3
    } pred_kind_e;

endpackage

// File: rtl/lap_slot.sv
module lap_slot
    import lap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            obs_i,
    input  logic [XLEN-1:0] addr_i,
    input  logic [XLEN-1:0] data_i,
    input  logic            st_valid_i,
    input  logic [XLEN-1:0] st_addr_i,
    output logic            ev_pred_o,
    output pred_kind_e      ev_kind_o,
    output logic [XLEN-1:0] ev_paddr_o,
    output logic            ev_mis_o,
    output logic            inval_o
);

    slot_state_e     state_q, state_d;
    logic [XLEN-1:0] last_q, last_d;
    logic [XLEN-1:0] data_q, data_d;
    logic [XLEN-1:0] stride_q, stride_d;
    logic            pend_q, pend_d;
    logic [XLEN-1:0] paddr_q, paddr_d;

    logic stride_hit, ptr_hit, store_hit;

    assign stride_hit = (addr_i == last_q + stride_q);
    assign ptr_hit    = (addr_i == data_q);
    assign store_hit  = st_valid_i && pend_q && (st_addr_i == paddr_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SL_EMPTY;
            last_q   <= '0;
            data_q   <= '0;
            stride_q <= '0;
            pend_q   <= 1'b0;
            paddr_q  <= '0;
        end else begin
            state_q  <= state_d;
            last_q   <= last_d;
            data_q   <= data_d;
            stride_q <= stride_d;
            pend_q   <= pend_d;
            paddr_q  <= paddr_d;
        end
    end

    // event outputs for the current observation or store
    always_comb begin
        ev_pred_o  = 1'b0;
        ev_kind_o  = KIND_NONE;
        ev_paddr_o = '0;
        ev_mis_o   = 1'b0;
        inval_o    = 1'b0;
        if (obs_i) begin
            unique case (state_q)
                SL_EMPTY, SL_SEEN: ;
                SL_TRAIN: begin
                    if (stride_hit) begin
                        ev_pred_o  = 1'b1;
                        ev_kind_o  = (stride_q == '0) ? KIND_CONST : KIND_STRIDE;
                        ev_paddr_o = addr_i + stride_q;
                    end else if (ptr_hit) begin
                        ev_pred_o  = 1'b1;
                        ev_kind_o  = KIND_PTR;
                        ev_paddr_o = data_i;
                    end
                end
                SL_STRIDE: begin
                    if (stride_hit) begin
                        ev_pred_o  = 1'b1;
                        ev_kind_o  = (stride_q == '0) ? KIND_CONST : KIND_STRIDE;
                        ev_paddr_o = addr_i + stride_q;
                    end else begin
                        ev_mis_o = 1'b1;
                    end
                end
                SL_POINTER: begin
                    if (ptr_hit) begin
                        ev_pred_o  = 1'b1;
                        ev_kind_o  = KIND_PTR;
                        ev_paddr_o = data_i;
                    end else begin
                        ev_mis_o = 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (store_hit) begin
            inval_o = 1'b1;
        end
    end

    // transitions
    always_comb begin
        state_d  = state_q;
        last_d   = last_q;
        data_d   = data_q;
        stride_d = stride_q;
        pend_d   = pend_q;
        paddr_d  = paddr_q;
        if (obs_i) begin
            last_d  = addr_i;
            data_d  = data_i;
            pend_d  = ev_pred_o;
            paddr_d = ev_paddr_o;
            unique case (state_q)
                SL_EMPTY: state_d = SL_SEEN;
                SL_SEEN: begin
                    stride_d = addr_i - last_q;
                    state_d  = SL_TRAIN;
                end
                SL_TRAIN: begin
                    if (stride_hit)   state_d = SL_STRIDE;
                    else if (ptr_hit) state_d = SL_POINTER;
                    else              stride_d = addr_i - last_q;
                end
                SL_STRIDE, SL_POINTER: begin
                    if (ev_mis_o) begin
                        stride_d = addr_i - last_q;
                        state_d  = SL_TRAIN;
                    end
                end
                default: state_d = SL_EMPTY;
            endcase
        end else if (inval_o) begin
            pend_d = 1'b0;
        end
    end

    // R3: a confirmed stride is only ever reached from training
    p_confirm_from_train_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SL_STRIDE && $past(state_q) != SL_STRIDE) |-> $past(state_q) == SL_TRAIN);

    // R5: pointer mode is only entered from training
    p_ptr_from_train_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SL_POINTER && $past(state_q) != SL_POINTER) |-> $past(state_q) == SL_TRAIN);

    // R6: a mispredict sends the slot back to training
    p_mis_retrains_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_mis_o |=> state_q == SL_TRAIN);

    // R7: an invalidated entry is no longer outstanding
    p_inval_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inval_o |=> !pend_q);

endmodule

// File: rtl/lap_event_mux.sv
module lap_event_mux
    import lap_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int XLEN      = 32,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic [SLOT_W-1:0] sel_i,
    input  logic              pred_i  [NUM_SLOTS],
    input  pred_kind_e        kind_i  [NUM_SLOTS],
    input  logic [XLEN-1:0]   paddr_i [NUM_SLOTS],
    input  logic              mis_i   [NUM_SLOTS],
    output logic              pred_o,
    output pred_kind_e        kind_o,
    output logic [XLEN-1:0]   paddr_o,
    output logic              mis_o
);

    always_comb begin
        pred_o  = 1'b0;
        kind_o  = KIND_NONE;
        paddr_o = '0;
        mis_o   = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (sel_i == SLOT_W'(i)) begin
                pred_o  = pred_i[i];
                kind_o  = kind_i[i];
                paddr_o = paddr_i[i];
                mis_o   = mis_i[i];
            end
        end
    end

endmodule

// File: rtl/lap_predictor.sv
module lap_predictor
    import lap_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int XLEN      = 32,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_valid,
    input  logic [SLOT_W-1:0]    ld_slot,
    input  logic [XLEN-1:0]      ld_addr,
    input  logic [XLEN-1:0]      ld_data,
    input  logic                 st_valid,
    input  logic [XLEN-1:0]      st_addr,
    output logic                 pred_valid,
    output logic [SLOT_W-1:0]    pred_slot,
    output logic [XLEN-1:0]      pred_addr,
    output logic [1:0]           pred_kind,
    output logic                 mispredict,
    output logic [SLOT_W-1:0]    mispredict_slot,
    output logic [NUM_SLOTS-1:0] inval_mask
);

    logic            ev_pred  [NUM_SLOTS];
    pred_kind_e      ev_kind  [NUM_SLOTS];
    logic [XLEN-1:0] ev_paddr [NUM_SLOTS];
    logic            ev_mis   [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] inval_d;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        lap_slot #(.XLEN(XLEN)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .obs_i      (ld_valid && ld_slot == SLOT_W'(g)),
            .addr_i     (ld_addr),
            .data_i     (ld_data),
            .st_valid_i (st_valid),
            .st_addr_i  (st_addr),
            .ev_pred_o  (ev_pred[g]),
            .ev_kind_o  (ev_kind[g]),
            .ev_paddr_o (ev_paddr[g]),
            .ev_mis_o   (ev_mis[g]),
            .inval_o    (inval_d[g])
        );
    end

    logic            sel_pred, sel_mis;
    pred_kind_e      sel_kind;
    logic [XLEN-1:0] sel_paddr;

    lap_event_mux #(.NUM_SLOTS(NUM_SLOTS), .XLEN(XLEN)) u_mux (
        .sel_i   (ld_slot),
        .pred_i  (ev_pred),
        .kind_i  (ev_kind),
        .paddr_i (ev_paddr),
        .mis_i   (ev_mis),
        .pred_o  (sel_pred),
        .kind_o  (sel_kind),
        .paddr_o (sel_paddr),
        .mis_o   (sel_mis)
    );

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_valid      <= 1'b0;
            pred_slot       <= '0;
            pred_addr       <= '0;
            pred_kind       <= KIND_NONE;
            mispredict      <= 1'b0;
            mispredict_slot <= '0;
            inval_mask      <= '0;
        end else begin
            pred_valid      <= ld_valid && sel_pred;
            pred_slot       <= ld_slot;
            pred_addr       <= sel_paddr;
            pred_kind       <= sel_kind;
            mispredict      <= ld_valid && sel_mis;
            mispredict_slot <= ld_slot;
            inval_mask      <= inval_d;
        end
    end

    // R3: a prediction answers the load of the previous cycle
    p_pred_follows_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |-> ($past(ld_valid) && pred_slot == $past(ld_slot)));

    // R6: a mispredict answers a load and never comes with a prediction
    p_mis_follows_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |-> ($past(ld_valid) && !pred_valid));

    // R7: an invalidate answers a store of the previous cycle
    p_inval_follows_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|inval_mask) |-> $past(st_valid));

    // R3: a prediction always carries a pattern kind
    p_pred_has_kind_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |-> pred_kind != KIND_NONE);

endmodule

// File: tb/tb_lap_predictor.sv
module tb_lap_predictor;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int XL = 32;

    typedef struct packed {
        logic          is_store;
        logic [1:0]    slot;
        logic [31:0]   addr;
        logic [31:0]   data;
        logic          e_pred;
        logic [1:0]    e_kind;
        logic [31:0]   e_paddr;
        logic          e_mis;
        logic [3:0]    e_inval;
        logic [7:0]    req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        // slot 0 stride 4: R2, R2, then R3 confirm
        '{1'b0, 2'd0, 32'h100, 32'h0, 1'b0, 2'd0, 32'h0,   1'b0, 4'h0, 8'd2},
        '{1'b0, 2'd0, 32'h104, 32'h0, 1'b0, 2'd0, 32'h0,   1'b0, 4'h0, 8'd2},
        '{1'b0, 2'd0, 32'h108, 32'h0, 1'b1, 2'd1, 32'h10C, 1'b0, 4'h0, 8'd3},
        // R7 store hit, then repeat store gives nothing
        '{1'b1, 2'd0, 32'h10C, 32'h0, 1'b0, 2'd0, 32'h0,   1'b0, 4'h1, 8'd7},
        '{1'b1, 2'd0, 32'h10C, 32'h0, 1'b0, 2'd0, 32'h0,   1'b0, 4'h0, 8'd7},
        '{1'b0, 2'd0, 32'h10C, 32'h0, 1'b1, 2'd1, 32'h110, 1'b0, 4'h0, 8'd3},
        // R8 non-matching store
        '{1'b1, 2'd0, 32'h200, 32'h0, 1'b0, 2'd0, 32'h0,   1'b0, 4'h0, 8'd8},
        // R6 mispredict, R10 training mismatch silent, R6 reconfirm
        '{1'b0, 2'd0, 32'h150, 32'h0, 1'b0, 2'd0, 32'h0,   1'b1, 4'h0, 8'd6},
        '{1'b0, 2'd0, 32'h154, 32'h0, 1'b0, 2'd0, 32'h0,   1'b0, 4'h0, 8'd10},
        '{1'b0, 2'd0, 32'h158, 32'h0, 1'b1, 2'd1, 32'h15C, 1'b0, 4'h0, 8'd6},
        // slot 1 constant: R4
        '{1'b0, 2'd1, 32'h300, 32'h0, 1'b0, 2'd0, 32'h0,   1'b0, 4'h0, 8'd2},
        '{1'b0, 2'd1, 32'h300, 32'h0, 1'b0, 2'd0, 32'h0,   1'b0, 4'h0, 8'd2},
        '{1'b0, 2'd1, 32'h300, 32'h0, 1'b1, 2'd2, 32'h300, 1'b0, 4'h0, 8'd4},
        // slot 2 pointer chase: R5, then R6 pointer mispredict
        '{1'b0, 2'd2, 32'h1000, 32'h2000, 1'b0, 2'd0, 32'h0,    1'b0, 4'h0, 8'd2},
        '{1'b0, 2'd2, 32'h2000, 32'h1F00, 1'b0, 2'd0, 32'h0,    1'b0, 4'h0, 8'd2},
        '{1'b0, 2'd2, 32'h1F00, 32'h5000, 1'b1, 2'd3, 32'h5000, 1'b0, 4'h0, 8'd5},
        '{1'b0, 2'd2, 32'h5000, 32'h0040, 1'b1, 2'd3, 32'h0040, 1'b0, 4'h0, 8'd5},
        '{1'b0, 2'd2, 32'h0044, 32'h0000, 1'b0, 2'd0, 32'h0,    1'b1, 4'h0, 8'd6},
        // R9 slots 0 and 1 unaffected by the others
        '{1'b0, 2'd0, 32'h15C, 32'h0, 1'b1, 2'd1, 32'h160, 1'b0, 4'h0, 8'd9},
        '{1'b0, 2'd1, 32'h300, 32'h0, 1'b1, 2'd2, 32'h300, 1'b0, 4'h0, 8'd9}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic ld_valid, st_valid;
    logic [1:0] ld_slot;
    logic [31:0] ld_addr, ld_data, st_addr;
    logic pred_valid, mispredict;
    logic [1:0] pred_slot, mispredict_slot, pred_kind;
    logic [31:0] pred_addr;
    logic [3:0] inval_mask;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lap_predictor #(.NUM_SLOTS(NS), .XLEN(XL)) dut (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_slot(ld_slot), .ld_addr(ld_addr), .ld_data(ld_data),
        .st_valid(st_valid), .st_addr(st_addr),
        .pred_valid(pred_valid), .pred_slot(pred_slot), .pred_addr(pred_addr),
        .pred_kind(pred_kind), .mispredict(mispredict), .mispredict_slot(mispredict_slot),
        .inval_mask(inval_mask)
    );

    task automatic check_out(input logic e_pred, input logic [1:0] e_slot,
                             input logic [1:0] e_kind, input logic [31:0] e_paddr,
                             input logic e_mis, input logic [3:0] e_inval, input int req);
        logic ok;
        ok = (pred_valid == e_pred) && (mispredict == e_mis) && (inval_mask == e_inval);
        if (e_pred) ok = ok && pred_slot == e_slot && pred_kind == e_kind && pred_addr == e_paddr;
        if (e_mis)  ok = ok && mispredict_slot == e_slot;
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL R%0d: got pred=%0b slot=%0d kind=%0d addr=%h mis=%0b mslot=%0d inval=%b; exp pred=%0b slot=%0d kind=%0d addr=%h mis=%0b inval=%b",
                     req, pred_valid, pred_slot, pred_kind, pred_addr, mispredict,
                     mispredict_slot, inval_mask, e_pred, e_slot, e_kind, e_paddr, e_mis, e_inval);
        end
    endtask

    // drive one operation at a falling edge, check at the next falling edge
    task automatic do_op(input vec_t v);
        @(negedge clk);
        ld_valid = !v.is_store;
        st_valid = v.is_store;
        ld_slot  = v.slot;
        ld_addr  = v.addr;
        ld_data  = v.data;
        st_addr  = v.addr;
        @(negedge clk);
        ld_valid = 1'b0;
        st_valid = 1'b0;
        check_out(v.e_pred, v.slot, v.e_kind, v.e_paddr, v.e_mis, v.e_inval, int'(v.req));
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog: got cycles=%0d expected below 20000", cycles);
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0;
        ld_valid = 1'b0; st_valid = 1'b0;
        ld_slot = '0; ld_addr = '0; ld_data = '0; st_addr = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_out(1'b0, 2'd0, 2'd0, 32'h0, 1'b0, 4'h0, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check_out(1'b0, 2'd0, 2'd0, 32'h0, 1'b0, 4'h0, 1);

        for (int i = 0; i < NV; i++) do_op(VECS[i]);

        // R7 corner: store to the outstanding address of slot 1 (constant 0x300)
        do_op('{1'b1, 2'd1, 32'h300, 32'h0, 1'b0, 2'd0, 32'h0, 1'b0, 4'h2, 8'd7});

        // R1: reset mid-run empties slot 0, so a load that would hit predicts nothing
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_out(1'b0, 2'd0, 2'd0, 32'h0, 1'b0, 4'h0, 1);
        rst_n = 1'b1;
        do_op('{1'b0, 2'd0, 32'h160, 32'h0, 1'b0, 2'd0, 32'h0, 1'b0, 4'h0, 8'd1});
        do_op('{1'b0, 2'd0, 32'h164, 32'h0, 1'b0, 2'd0, 32'h0, 1'b0, 4'h0, 8'd1});

        // R10: training mismatch that also fails the pointer test stays silent
        do_op('{1'b0, 2'd0, 32'h900, 32'h0, 1'b0, 2'd0, 32'h0, 1'b0, 4'h0, 8'd10});
        // new stride 0x79C confirms on the next matching load (R3)
        do_op('{1'b0, 2'd0, 32'h109C, 32'h0, 1'b1, 2'd1, 32'h1838, 1'b0, 4'h0, 8'd3});

        finish_run();
    end

endmodule